// File: doc/BRIEF.md
# Stream M/N Ratio Reducer

This block turns a display mode's timing into the two M/N ratio pairs a transport needs to carry a pixel stream over a fixed-rate serial link. One pair relates the payload byte rate to the total lane bandwidth. The other pair relates the pixel clock to the link symbol clock. The block also returns the transfer-unit length field. Every value it returns fits a 24-bit register field.

A request carries four values: the pixel clock in kHz, the link clock, and optional bits-per-pixel and lane-count overrides. The block forms the raw products at 40 bits. It then halves both members of a pair together, one step per clock and for both pairs at once, until each member fits in 24 bits.

Both sides use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the result has been handed over. The result is offered with `rsp_valid` and is held unchanged for as long as `rsp_ready` stays low. The result is consumed on the edge where both are high. The request inputs are sampled only on the accepting edge, so the source may change them afterwards.

Top module: `mn_ratio_calc`

## Requirements
- R1: The raw data M is the pixel clock times the effective bits per pixel, shifted right by 3 (integer bytes).
- R2: The raw data N is the link clock times the effective lane count.
- R3: The raw link M is the pixel clock and the raw link N is the link clock.
- R4: Each pair is reduced independently. While either member exceeds 0xFFFFFF, both members shift right by one together, one shift per clock. The reported values are the first ones at which both members are at most 0xFFFFFF.
- R5: `tu_size_m1` reports the transfer-unit length of 64 encoded as length minus one, which is 63.
- R6: When `bpp_ovr_en` is 0 the effective bits per pixel is 24. When it is 1 the effective value is `bpp_ovr`.
- R7: When `lane_ovr_en` is 0 the effective lane count is 4. When it is 1 the effective value is `lane_ovr`.
- R8: `rsp_valid` rises exactly S+1 clocks after the accepting edge, where S is the larger of the two pairs' shift counts.
- R9: While a result is pending and `rsp_ready` is low, `rsp_valid` stays high and every result output stays stable. `req_ready` is low from acceptance until the result is consumed. Request inputs changed after acceptance do not affect the result.
- R10: After reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| pix_clk_khz | input | 28 | Pixel clock in kHz |
| link_clk | input | 28 | Link clock, same units as the pixel clock |
| bpp_ovr_en | input | 1 | Use `bpp_ovr` instead of the default of 24 |
| bpp_ovr | input | 8 | Bits-per-pixel override |
| lane_ovr_en | input | 1 | Use `lane_ovr` instead of the default of 4 |
| lane_ovr | input | 5 | Lane-count override |
| rsp_valid | output | 1 | Result pending |
| rsp_ready | input | 1 | Consumer takes the result |
| data_m | output | 24 | Reduced data M |
| data_n | output | 24 | Reduced data N |
| link_m | output | 24 | Reduced link M |
| link_n | output | 24 | Reduced link N |
| tu_size_m1 | output | 6 | Transfer-unit length minus one |

## Verification
The hardest case to reach is one where the two pairs need different shift counts. In that case one reducer has already frozen while the other is still shifting. Only the longer count sets the completion time, and a frozen pair must not shift again.

The stimulus reaches these cases with a sweep. It crosses pixel clocks placed on both sides of the 24-bit boundary with link clocks and override settings whose products land below, at and well above it. The bench also holds back the result for a varying number of cycles and scrambles the request inputs while the block is busy.

// File: rtl/mn_ratio_pkg.sv
package mn_ratio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } mn_state_e;

  localparam int unsigned DEF_BPP   = 24;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned NPAIR     = 2;
  localparam int unsigned PAIR_DATA = 0;
  localparam int unsigned PAIR_LINK = 1;
endpackage

// File: rtl/mn_operand_calc.sv
module mn_operand_calc #(
  parameter int unsigned PCLK_W = 28,
  parameter int unsigned LCLK_W = 28,
  parameter int unsigned BPP_W  = 8,
  parameter int unsigned LANE_W = 5,
  parameter int unsigned PROD_W = 40
) (
  input  logic [PCLK_W-1:0] pix_clk,
  input  logic [LCLK_W-1:0] lnk_clk,
  input  logic              bpp_en,
  input  logic [BPP_W-1:0]  bpp_val,
  input  logic              lane_en,
  input  logic [LANE_W-1:0] lane_val,
  output logic [PROD_W-1:0] raw_dm,
  output logic [PROD_W-1:0] raw_dn,
  output logic [PROD_W-1:0] raw_lm,
  output logic [PROD_W-1:0] raw_ln
);
  import mn_ratio_pkg::*;

  localparam logic [BPP_W-1:0]  BPP_DEF  = BPP_W'(DEF_BPP);
  localparam logic [LANE_W-1:0] LANE_DEF = LANE_W'(DEF_LANES);

  logic [BPP_W-1:0]  eff_bpp;
  logic [LANE_W-1:0] eff_lanes;
  logic [PROD_W-1:0] pix_x, lnk_x, bpp_x, lane_x, bit_rate;

  always_comb begin
    eff_bpp   = bpp_en  ? bpp_val  : BPP_DEF;
    eff_lanes = lane_en ? lane_val : LANE_DEF;
    pix_x     = PROD_W'(pix_clk);
    lnk_x     = PROD_W'(lnk_clk);
    bpp_x     = PROD_W'(eff_bpp);
    lane_x    = PROD_W'(eff_lanes);
    bit_rate  = pix_x * bpp_x;
    raw_dm    = bit_rate >> 3;
    raw_dn    = lnk_x * lane_x;
    raw_lm    = pix_x;
    raw_ln    = lnk_x;
  end
endmodule

// File: rtl/mn_pair_reducer.sv
module mn_pair_reducer #(
  parameter int unsigned PROD_W = 40,
  parameter int unsigned OUT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [PROD_W-1:0] m_in,
  input  logic [PROD_W-1:0] n_in,
  output logic [PROD_W-1:0] m_q,
  output logic [PROD_W-1:0] n_q,
  output logic              fits
);
  localparam int unsigned HI_W = PROD_W - OUT_W;

  logic m_big, n_big;

  always_comb begin
    m_big = (m_q[PROD_W-1:OUT_W] != HI_W'(0));
    n_big = (n_q[PROD_W-1:OUT_W] != HI_W'(0));
    fits  = !(m_big || n_big);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
    end else if (load) begin
      m_q <= m_in;
      n_q <= n_in;
    end else if (step && !fits) begin
      m_q <= m_q >> 1;
      n_q <= n_q >> 1;
    end
  end
endmodule

// File: rtl/mn_ratio_calc.sv
module mn_ratio_calc #(
  parameter int unsigned PCLK_W  = 28,
  parameter int unsigned LCLK_W  = 28,
  parameter int unsigned BPP_W   = 8,
  parameter int unsigned LANE_W  = 5,
  parameter int unsigned PROD_W  = 40,
  parameter int unsigned OUT_W   = 24,
  parameter int unsigned TU_SIZE = 64,
  localparam int unsigned TU_W   = $clog2(TU_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PCLK_W-1:0] pix_clk_khz,
  input  logic [LCLK_W-1:0] link_clk,
  input  logic              bpp_ovr_en,
  input  logic [BPP_W-1:0]  bpp_ovr,
  input  logic              lane_ovr_en,
  input  logic [LANE_W-1:0] lane_ovr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [OUT_W-1:0]  data_m,
  output logic [OUT_W-1:0]  data_n,
  output logic [OUT_W-1:0]  link_m,
  output logic [OUT_W-1:0]  link_n,
  output logic [TU_W-1:0]   tu_size_m1
);
  import mn_ratio_pkg::*;

  mn_state_e state_q, state_d;

  logic              accept, busy, all_fit;
  logic [PROD_W-1:0] raw_m [NPAIR];
  logic [PROD_W-1:0] raw_n [NPAIR];
  logic [PROD_W-1:0] red_m [NPAIR];
  logic [PROD_W-1:0] red_n [NPAIR];
  logic [NPAIR-1:0]  pair_fit;

  mn_operand_calc #(
    .PCLK_W(PCLK_W), .LCLK_W(LCLK_W), .BPP_W(BPP_W),
    .LANE_W(LANE_W), .PROD_W(PROD_W)
  ) u_operands (
    .pix_clk (pix_clk_khz),
    .lnk_clk (link_clk),
    .bpp_en  (bpp_ovr_en),
    .bpp_val (bpp_ovr),
    .lane_en (lane_ovr_en),
    .lane_val(lane_ovr),
    .raw_dm  (raw_m[PAIR_DATA]),
    .raw_dn  (raw_n[PAIR_DATA]),
    .raw_lm  (raw_m[PAIR_LINK]),
    .raw_ln  (raw_n[PAIR_LINK])
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    mn_pair_reducer #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_red (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .step (busy),
      .m_in (raw_m[g]),
      .n_in (raw_n[g]),
      .m_q  (red_m[g]),
      .n_q  (red_n[g]),
      .fits (pair_fit[g])
    );
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    rsp_valid = (state_q == ST_RESP);
    busy      = (state_q == ST_BUSY);
    accept    = req_valid && req_ready;
    all_fit   = &pair_fit;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_BUSY;
      ST_BUSY: if (all_fit) state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign data_m     = red_m[PAIR_DATA][OUT_W-1:0];
  assign data_n     = red_n[PAIR_DATA][OUT_W-1:0];
  assign link_m     = red_m[PAIR_LINK][OUT_W-1:0];
  assign link_n     = red_n[PAIR_LINK][OUT_W-1:0];
  assign tu_size_m1 = TU_W'(TU_SIZE - 1);
endmodule

// File: rtl/mn_ratio_chk.sv
module mn_ratio_chk #(
  parameter int unsigned PROD_W = 40,
  parameter int unsigned OUT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              busy,
  input logic [PROD_W-1:0] dm_q,
  input logic [PROD_W-1:0] dn_q,
  input logic [PROD_W-1:0] lm_q,
  input logic [PROD_W-1:0] ln_q
);
  localparam int unsigned HI_W = PROD_W - OUT_W;

  a_r4_fit_at_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (dm_q[PROD_W-1:OUT_W] == HI_W'(0)) && (dn_q[PROD_W-1:OUT_W] == HI_W'(0))
               && (lm_q[PROD_W-1:OUT_W] == HI_W'(0)) && (ln_q[PROD_W-1:OUT_W] == HI_W'(0)));

  a_r4_data_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (dm_q[PROD_W-1:OUT_W] != HI_W'(0))) |=> (dm_q == ($past(dm_q) >> 1)) && (dn_q == ($past(dn_q) >> 1)));

  a_r4_link_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ln_q[PROD_W-1:OUT_W] != HI_W'(0))) |=> (lm_q == ($past(lm_q) >> 1)) && (ln_q == ($past(ln_q) >> 1)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(dm_q) && $stable(dn_q) && $stable(lm_q) && $stable(ln_q));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
endmodule

bind mn_ratio_calc mn_ratio_chk #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .busy     (busy),
  .dm_q     (red_m[0]),
  .dn_q     (red_n[0]),
  .lm_q     (red_m[1]),
  .ln_q     (red_n[1])
);

// File: tb/mn_ratio_calc_tb_top.sv
module mn_ratio_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] pix_clk_khz = '0;
  logic [27:0] link_clk = '0;
  logic        bpp_ovr_en = 1'b0;
  logic [7:0]  bpp_ovr = '0;
  logic        lane_ovr_en = 1'b0;
  logic [4:0]  lane_ovr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [23:0] data_m, data_n, link_m, link_n;
  logic [5:0]  tu_size_m1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mn_ratio_calc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .pix_clk_khz(pix_clk_khz), .link_clk(link_clk), .bpp_ovr_en(bpp_ovr_en),
    .bpp_ovr(bpp_ovr), .lane_ovr_en(lane_ovr_en), .lane_ovr(lane_ovr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .data_m(data_m),
    .data_n(data_n), .link_m(link_m), .link_n(link_n), .tu_size_m1(tu_size_m1)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reduce(inout longint m, inout longint n, output int s);
    s = 0;
    while (m > 64'hFFFFFF || n > 64'hFFFFFF) begin
      m = m >> 1;
      n = n >> 1;
      s++;
    end
  endtask

  task automatic run_one(longint pc, longint lc, bit be, int bv, bit le, int lv, int hold);
    longint e_dm, e_dn, e_lm, e_ln;
    int s1, s2, s, cnt;
    longint bpp_e, lanes_e;
    bit stable_ok;
    logic [23:0] h_dm, h_dn, h_lm, h_ln;
    bpp_e   = be ? bv : 24;   // R6
    lanes_e = le ? lv : 4;    // R7
    e_dm = (pc * bpp_e) >> 3; // R1
    e_dn = lc * lanes_e;      // R2
    e_lm = pc;                // R3
    e_ln = lc;
    reduce(e_dm, e_dn, s1);   // R4
    reduce(e_lm, e_ln, s2);
    s = (s1 > s2) ? s1 : s2;

    @(negedge clk);
    pix_clk_khz = pc[27:0]; link_clk = lc[27:0];
    bpp_ovr_en = be; bpp_ovr = bv[7:0]; lane_ovr_en = le; lane_ovr = lv[4:0];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    pix_clk_khz = ~pc[27:0]; link_clk = 28'h0000123;
    bpp_ovr_en = ~be; bpp_ovr = 8'd7; lane_ovr_en = ~le; lane_ovr = 5'd17;
    cnt = 0;
    check("R9 req_ready low while busy", req_ready, 0);
    while (!rsp_valid && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
    check("R8 latency", cnt, s + 1);
    check("R1 data_m", data_m, e_dm);
    check("R2 data_n", data_n, e_dn);
    check("R3 link_m", link_m, e_lm);
    check("R3 link_n", link_n, e_ln);
    check("R5 tu_size_m1", tu_size_m1, 63);
    h_dm = data_m; h_dn = data_n; h_lm = link_m; h_ln = link_n;
    stable_ok = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || data_m != h_dm || data_n != h_dn ||
          link_m != h_lm || link_n != h_ln) stable_ok = 1'b0;
    end
    check("R9 held under back-pressure", stable_ok, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 consumed rsp_valid", rsp_valid, 0);
    check("R9 ready again", req_ready, 1);
  endtask

  initial begin
    longint pcs [8] = '{0, 1, 148500, 64'hFFFFFF, 64'h1000000, 64'h2345678, 64'hFFFFFFF, 64'h8000001};
    longint lcs [3] = '{162000, 64'h1FFFFFF, 64'hFFFFFFF};
    int bvs [4] = '{-1, 18, 30, 255};
    int lvs [4] = '{-1, 1, 2, 31};
    int idx;
    repeat (3) @(negedge clk);
    check("R10 reset req_ready", req_ready, 1);
    check("R10 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset req_ready", req_ready, 1);
    check("R10 after reset rsp_valid", rsp_valid, 0);
    idx = 0;
    foreach (pcs[i]) foreach (lcs[j]) foreach (bvs[b]) foreach (lvs[l]) begin
      run_one(pcs[i], lcs[j], bvs[b] >= 0, (bvs[b] >= 0) ? bvs[b] : 0,
              lvs[l] >= 0, (lvs[l] >= 0) ? lvs[l] : 0, idx % 4);
      idx++;
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule